// File: doc/BRIEF.md
# W-Buffer Transfer Controller

This controller moves single 24-bit words between memory and a one-word buffer register that it shares with an external device. An output transfer reads a memory word and places it in the buffer. An input transfer takes the word the device left in the buffer, writes it to memory, and then empties the buffer so the device can load it again. The device side loads the buffer, which sets a full flag, and unloads it, which clears the flag.

When a transfer is not synchronized by an interrupt, the controller holds the processor with a stall output until the buffer is ready. For an output transfer, ready means empty. For an input transfer, ready means full. When the interrupt-synchronized flag is set on the command, the interrupt has already provided the timing, so the controller does not wait at all. The stall output stays high from the cycle after a command is accepted through the final transfer cycle. A one-cycle done pulse marks that final cycle.

Top module: `wbuf_xfer_ctrl`

## Requirements
- R1: After a synchronous reset, stall, done, buf_full, mem_rd_en and mem_wr_en are 0, and buf_data is 0.
- R2: A cmd_valid seen while idle starts a transfer, and stall is 1 from the next cycle through the done cycle. A cmd_valid seen while a transfer is in progress is ignored and starts no later transfer.
- R3: An output transfer (cmd_dir=0) with cmd_intr=0 issues no memory read while buf_full is 1, and stall stays 1 during that wait.
- R4: Once an output transfer may proceed, mem_rd_en is 1 for one cycle with mem_addr equal to cmd_addr. The next cycle is the done cycle. After it, the buffer holds the word that memory returned (read data is valid one cycle after mem_rd_en) and buf_full is 1. Without a wait, stall is high for 2 cycles.
- R5: An input transfer (cmd_dir=1) with cmd_intr=0 issues no memory write while buf_full is 0, and stall stays 1 during that wait.
- R6: Once an input transfer may proceed, one cycle later mem_wr_en is 1 for one cycle, with mem_addr equal to cmd_addr and mem_wdata equal to the buffer word. The cycle after the write is the done cycle. Without a wait, stall is high for 3 cycles.
- R7: After the done cycle of an input transfer, buf_full is 0 and buf_data is 0.
- R8: With cmd_intr=1, a transfer proceeds at once whatever the value of buf_full. An output transfer overwrites a full buffer. An input transfer writes whatever word the buffer holds.
- R9: Same-cycle conflicts are resolved removal first, then fill. A dev_load in the controller's clearing cycle leaves buf_full=1 with the device word. A dev_unload in the controller's fill cycle leaves buf_full=1 with the memory word.
- R10: dev_load sets buf_full and stores dev_data, which appears on buf_data. dev_unload clears buf_full and leaves buf_data unchanged.
- R11: mem_rd_en is asserted only in output transfers and mem_wr_en only in input transfers. The two are never 1 together, and each is asserted at most once per transfer.
- R12: done is a single-cycle pulse and is 1 only while stall is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a transfer (taken only when idle) |
| cmd_dir | input | 1 | 0 = memory to buffer, 1 = buffer to memory |
| cmd_intr | input | 1 | 1 = interrupt-synchronized, no wait |
| cmd_addr | input | 14 | Effective memory address |
| stall | output | 1 | Processor lock-up while a transfer runs |
| done | output | 1 | Final transfer cycle pulse |
| mem_addr | output | 14 | Memory address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rdata | input | 24 | Memory read data, one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 24 | Memory write data |
| dev_load | input | 1 | Device writes dev_data into the buffer |
| dev_data | input | 24 | Device word |
| dev_unload | input | 1 | Device takes the buffer word |
| buf_data | output | 24 | Buffer contents |
| buf_full | output | 1 | Buffer full flag |

## Verification
The bench holds each non-synchronized transfer against a buffer in the wrong state for several cycles. A controller that ignored the full flag would read or write memory early, and the scoreboard would see an access it did not expect. It also places a device load on the clearing cycle and a device unload on the fill cycle. A wrong priority there would either lose the device's word or drop the freshly read memory word, and the buffer state would show the loss. Interrupt-synchronized commands are issued against a buffer in the "wrong" state, so a design that still waited would overrun the expected cycle count. A command sent while the controller is busy must not cause any additional memory access.

// File: rtl/wbx_pkg.sv
package wbx_pkg;

    localparam int WBX_DATA_W = 24;
    localparam int WBX_ADDR_W = 14;

    typedef logic [WBX_DATA_W-1:0] word_t;
    typedef logic [WBX_ADDR_W-1:0] addr_t;

    typedef enum logic {
        XFER_OUT = 1'b0,
        XFER_IN  = 1'b1
    } xdir_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OUT_RD,
        S_OUT_FILL,
        S_IN_CHK,
        S_IN_WR,
        S_IN_CLR
    } seq_state_e;

    typedef struct packed {
        xdir_e dir;
        logic  intr;
        addr_t addr;
    } xcmd_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic fill;
        logic clr;
        logic done;
        logic busy;
    } seq_ctl_t;

    // A transfer may go ahead when synchronized by interrupt, or when the
    // buffer is in the state the direction needs.
    function automatic logic may_proceed(xdir_e dir, logic intr, logic full);
        if (intr)
            return 1'b1;
        return (dir == XFER_OUT) ? !full : full;
    endfunction

endpackage

// File: rtl/wbx_buffer.sv
module wbx_buffer
    import wbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  dev_load,
    input  word_t dev_data,
    input  logic  dev_unload,
    input  logic  proc_fill,
    input  word_t proc_data,
    input  logic  proc_clr,
    output word_t data,
    output logic  full
);

    word_t nxt_data;
    logic  nxt_full;

    // Removals are applied first, then fills, so no word is lost.
    always_comb begin
        nxt_data = data;
        nxt_full = full;
        if (dev_unload)
            nxt_full = 1'b0;
        if (proc_clr) begin
            nxt_full = 1'b0;
            nxt_data = '0;
        end
        if (dev_load) begin
            nxt_full = 1'b1;
            nxt_data = dev_data;
        end
        if (proc_fill) begin
            nxt_full = 1'b1;
            nxt_data = proc_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else begin
            data <= nxt_data;
            full <= nxt_full;
        end
    end

    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        (proc_clr && !dev_load) |=> (!full && data == '0));

    p_load_beats_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (proc_clr && dev_load) |=> (full && data == $past(dev_data)));

    p_fill_beats_unload_r9: assert property (@(posedge clk) disable iff (rst)
        proc_fill |=> (full && data == $past(proc_data)));

    p_unload_keeps_data_r10: assert property (@(posedge clk) disable iff (rst)
        (dev_unload && !dev_load && !proc_fill && !proc_clr) |=> (!full && $stable(data)));

endmodule

// File: rtl/wbx_seq.sv
module wbx_seq
    import wbx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  xcmd_t    cmd,
    input  logic     buf_full,
    output seq_ctl_t ctl,
    output addr_t    xaddr
);

    seq_state_e state, nxt_state;
    xcmd_t      cur;
    logic       go;

    assign go = may_proceed(cur.dir, cur.intr, buf_full);

    always_comb begin
        nxt_state = state;
        case (state)
            S_IDLE:     if (cmd_valid)
                            nxt_state = (cmd.dir == XFER_OUT) ? S_OUT_RD : S_IN_CHK;
            S_OUT_RD:   if (go) nxt_state = S_OUT_FILL;
            S_OUT_FILL: nxt_state = S_IDLE;
            S_IN_CHK:   if (go) nxt_state = S_IN_WR;
            S_IN_WR:    nxt_state = S_IN_CLR;
            S_IN_CLR:   nxt_state = S_IDLE;
            default:    nxt_state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cur   <= '0;
        end else begin
            state <= nxt_state;
            if (state == S_IDLE && cmd_valid)
                cur <= cmd;
        end
    end

    always_comb begin
        ctl      = '0;
        ctl.busy = (state != S_IDLE);
        ctl.rd   = (state == S_OUT_RD) && go;
        ctl.fill = (state == S_OUT_FILL);
        ctl.wr   = (state == S_IN_WR);
        ctl.clr  = (state == S_IN_CLR);
        ctl.done = ctl.fill || ctl.clr;
    end

    assign xaddr = cur.addr;

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && cmd_valid) |=> ctl.busy);

    p_out_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_OUT_RD && !cur.intr && buf_full) |=> (state == S_OUT_RD));

    p_read_then_done_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.rd |=> ctl.done);

    p_in_waits_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_IN_CHK && !cur.intr && !buf_full) |=> (state == S_IN_CHK));

    p_write_then_done_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |=> (ctl.done && !ctl.wr));

    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(ctl.rd && ctl.wr));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> !ctl.done);

    p_done_in_stall_r12: assert property (@(posedge clk) disable iff (rst)
        ctl.done |-> ctl.busy);

endmodule

// File: rtl/wbuf_xfer_ctrl.sv
module wbuf_xfer_ctrl
    import wbx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic                  cmd_dir,
    input  logic                  cmd_intr,
    input  logic [WBX_ADDR_W-1:0] cmd_addr,
    output logic                  stall,
    output logic                  done,
    output logic [WBX_ADDR_W-1:0] mem_addr,
    output logic                  mem_rd_en,
    input  logic [WBX_DATA_W-1:0] mem_rdata,
    output logic                  mem_wr_en,
    output logic [WBX_DATA_W-1:0] mem_wdata,
    input  logic                  dev_load,
    input  logic [WBX_DATA_W-1:0] dev_data,
    input  logic                  dev_unload,
    output logic [WBX_DATA_W-1:0] buf_data,
    output logic                  buf_full
);

    xcmd_t    cmd;
    seq_ctl_t ctl;
    addr_t    xaddr;
    word_t    bdata;
    logic     bfull;

    assign cmd.dir  = xdir_e'(cmd_dir);
    assign cmd.intr = cmd_intr;
    assign cmd.addr = cmd_addr;

    wbx_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .buf_full  (bfull),
        .ctl       (ctl),
        .xaddr     (xaddr)
    );

    wbx_buffer i_buf (
        .clk        (clk),
        .rst        (rst),
        .dev_load   (dev_load),
        .dev_data   (dev_data),
        .dev_unload (dev_unload),
        .proc_fill  (ctl.fill),
        .proc_data  (mem_rdata),
        .proc_clr   (ctl.clr),
        .data       (bdata),
        .full       (bfull)
    );

    assign stall     = ctl.busy;
    assign done      = ctl.done;
    assign mem_addr  = xaddr;
    assign mem_rd_en = ctl.rd;
    assign mem_wr_en = ctl.wr;
    assign mem_wdata = bdata;
    assign buf_data  = bdata;
    assign buf_full  = bfull;

    p_write_needs_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en || mem_wr_en) |-> stall);

    p_write_clears_buffer_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !dev_load) |-> ##2 (!buf_full || $past(dev_load)));

endmodule

// File: tb/test_wbuf_xfer_ctrl.sv
module test_wbuf_xfer_ctrl;
    import wbx_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_dir, cmd_intr;
    logic [13:0] cmd_addr;
    logic        stall, done, mem_rd_en, mem_wr_en;
    logic [13:0] mem_addr;
    logic [23:0] mem_rdata, mem_wdata;
    logic        dev_load, dev_unload;
    logic [23:0] dev_data, buf_data;
    logic        buf_full;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wbuf_xfer_ctrl i_wbuf_xfer_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
        .cmd_intr(cmd_intr), .cmd_addr(cmd_addr), .stall(stall), .done(done),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .dev_load(dev_load),
        .dev_data(dev_data), .dev_unload(dev_unload), .buf_data(buf_data),
        .buf_full(buf_full)
    );

    // Memory model with one-cycle read latency
    logic [23:0] mem [16];
    initial for (int i = 0; i < 16; i++) mem[i] = 24'h0A0000 + 24'(i) * 24'h050301;
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[3:0]];
        if (mem_wr_en) mem[mem_addr[3:0]] <= mem_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Scoreboard of expected memory accesses
    typedef struct {
        bit          is_wr;
        logic [13:0] addr;
        logic [23:0] data;
    } exp_t;
    exp_t sb[$];

    task automatic push_rd(input logic [13:0] a);
        exp_t e; e.is_wr = 0; e.addr = a; e.data = '0; sb.push_back(e);
    endtask
    task automatic push_wr(input logic [13:0] a, input logic [23:0] d);
        exp_t e; e.is_wr = 1; e.addr = a; e.data = d; sb.push_back(e);
    endtask

    exp_t got_e;
    always @(negedge clk) begin
        if (!rst && (mem_rd_en || mem_wr_en)) begin
            chk("R11 rd/wr exclusive", {31'b0, mem_rd_en & mem_wr_en}, 32'd0);
            if (sb.size() == 0) begin
                chk("R11 unexpected memory access", 32'd1, 32'd0);
            end else begin
                got_e = sb.pop_front();
                chk("R11 access kind", {31'b0, mem_wr_en}, {31'b0, got_e.is_wr});
                chk("R4 R6 access address", {18'b0, mem_addr}, {18'b0, got_e.addr});
                if (got_e.is_wr) chk("R6 write data", {8'b0, mem_wdata}, {8'b0, got_e.data});
            end
        end
    end

    task automatic start(input logic dir, input logic intr, input logic [13:0] a);
        @(negedge clk);
        cmd_valid = 1; cmd_dir = dir; cmd_intr = intr; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic wait_done(output int n);
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R12 stall during done", {31'b0, stall}, 32'd1);
    endtask

    task automatic dev_put(input logic [23:0] d);
        @(negedge clk); dev_load = 1; dev_data = d;
        @(negedge clk); dev_load = 0;
    endtask

    task automatic dev_take();
        @(negedge clk); dev_unload = 1;
        @(negedge clk); dev_unload = 0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        int n;
        logic [23:0] w;
        rst = 1; cmd_valid = 0; cmd_dir = 0; cmd_intr = 0; cmd_addr = '0;
        dev_load = 0; dev_unload = 0; dev_data = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 stall", {31'b0, stall}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 buf_full", {31'b0, buf_full}, 32'd0);
        chk("R1 buf_data", {8'b0, buf_data}, 32'd0);
        chk("R1 strobes", {30'b0, mem_rd_en, mem_wr_en}, 32'd0);

        // R4 output transfer, empty buffer, no wait
        push_rd(14'd3);
        start(1'b0, 1'b0, 14'd3);
        chk("R2 stall after accept", {31'b0, stall}, 32'd1);
        wait_done(n);
        chk("R4 output cycles", n, 32'd2);
        @(negedge clk);
        chk("R2 stall released", {31'b0, stall}, 32'd0);
        chk("R4 buffer word", {8'b0, buf_data}, {8'b0, mem[3]});
        chk("R4 buffer full", {31'b0, buf_full}, 32'd1);

        // R3 output lock-up while buffer full
        push_rd(14'd4);
        start(1'b0, 1'b0, 14'd4);
        repeat (4) begin
            chk("R3 stall while full", {31'b0, stall}, 32'd1);
            chk("R3 no read while full", {31'b0, mem_rd_en}, 32'd0);
            @(negedge clk);
        end
        chk("R10 device sees word", {8'b0, buf_data}, {8'b0, mem[3]});
        dev_take();
        wait_done(n);
        chk("R4 cycles after release", n, 32'd2);
        @(negedge clk);
        chk("R4 buffer word after wait", {8'b0, buf_data}, {8'b0, mem[4]});

        // R6 input transfer, full buffer, no wait
        w = mem[4];
        push_wr(14'd7, w);
        start(1'b1, 1'b0, 14'd7);
        wait_done(n);
        chk("R6 input cycles", n, 32'd3);
        @(negedge clk);
        chk("R7 buffer empty", {31'b0, buf_full}, 32'd0);
        chk("R7 buffer zero", {8'b0, buf_data}, 32'd0);
        chk("R6 memory written", {8'b0, mem[7]}, {8'b0, w});

        // R5 input lock-up while buffer empty
        push_wr(14'd8, 24'h00BEEF);
        start(1'b1, 1'b0, 14'd8);
        repeat (4) begin
            chk("R5 stall while empty", {31'b0, stall}, 32'd1);
            chk("R5 no write while empty", {31'b0, mem_wr_en}, 32'd0);
            @(negedge clk);
        end
        dev_put(24'h00BEEF);
        wait_done(n);
        chk("R5 cycles after fill", n, 32'd3);
        @(negedge clk);
        chk("R7 empty after wait", {31'b0, buf_full}, 32'd0);

        // R8 interrupt-synchronized output over a full buffer
        dev_put(24'h111111);
        push_rd(14'd5);
        start(1'b0, 1'b1, 14'd5);
        wait_done(n);
        chk("R8 output no wait", n, 32'd2);
        @(negedge clk);
        chk("R8 buffer overwritten", {8'b0, buf_data}, {8'b0, mem[5]});

        // R10 unload clears flag, keeps data; R8 input over an empty buffer
        dev_take();
        chk("R10 unload clears full", {31'b0, buf_full}, 32'd0);
        chk("R10 unload keeps data", {8'b0, buf_data}, {8'b0, mem[5]});
        push_wr(14'd9, mem[5]);
        start(1'b1, 1'b1, 14'd9);
        wait_done(n);
        chk("R8 input no wait", n, 32'd3);

        // R9 device load in the clearing cycle
        dev_put(24'h222222);
        push_wr(14'd10, 24'h222222);
        start(1'b1, 1'b0, 14'd10);
        wait_done(n);
        dev_load = 1; dev_data = 24'h333333;
        @(negedge clk);
        dev_load = 0;
        chk("R9 load survives clear full", {31'b0, buf_full}, 32'd1);
        chk("R9 load survives clear data", {8'b0, buf_data}, 32'h333333);

        // R9 device unload in the fill cycle
        push_rd(14'd6);
        start(1'b0, 1'b1, 14'd6);
        wait_done(n);
        dev_unload = 1;
        @(negedge clk);
        dev_unload = 0;
        chk("R9 fill survives unload full", {31'b0, buf_full}, 32'd1);
        chk("R9 fill survives unload data", {8'b0, buf_data}, {8'b0, mem[6]});

        // R2 command while busy is ignored
        push_rd(14'd11);
        start(1'b0, 1'b0, 14'd11);
        cmd_valid = 1; cmd_dir = 1; cmd_addr = 14'd12;
        @(negedge clk);
        cmd_valid = 0;
        chk("R2 busy stall", {31'b0, stall}, 32'd1);
        dev_take();
        wait_done(n);
        @(negedge clk);
        chk("R2 no extra transfer", {31'b0, stall}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R2 still idle", {31'b0, stall}, 32'd0);
        chk("R2 buffer from first command", {8'b0, buf_data}, {8'b0, mem[11]});
        chk("R11 all expected accesses seen", sb.size(), 32'd0);

        finish_run();
    end

endmodule